// File: doc/BRIEF.md
# Spin-Loop Pause Exit Detector

This block watches pause-hint events issued by a guest and decides when a virtual-machine exit should be requested for them. There are two exit causes. With the unconditional control on, every pause requests an exit. With spin-loop detection on and the guest at privilege level 0, the block groups pauses into bursts: a pause that comes more than a gap value after the previous one opens a new burst, and a pause inside a burst that comes more than a window value after that burst's first pause requests an exit.

The block keeps two timestamps: when the current burst began and when the last qualifying pause arrived. The timestamp input is a free-running count owned by the surrounding core. Differences are taken with modular subtraction, so a counter that wraps does not break a burst. A small state machine turns each decision into a one-cycle exit request with a reason code, in the cycle after the pause is sampled. The machine has two states. WATCH is the idle state. RAISE drives the request. The transitions are WATCH to RAISE on a trigger, RAISE to RAISE on a trigger in the next cycle, RAISE to WATCH when no trigger follows, and WATCH to WATCH when nothing triggers.

Top module: `spin_pause_exit`

## Requirements
- R1: When `uncond_en` is 1, every pause requests an exit with reason 1 in the next cycle. This takes precedence over spin-loop detection, and such a pause leaves both timestamps unchanged.
- R2: A pause is qualifying only when `uncond_en` is 0, `loop_en` is 1 and `cpl` is 0. Any other pause with `uncond_en` at 0 requests no exit and changes no timestamp.
- R3: A qualifying pause for which (now − last) > `gap_val` makes `now` the new first timestamp and requests no exit. A difference exactly equal to `gap_val` keeps the current burst.
- R4: A qualifying pause that keeps the current burst requests an exit with reason 2 when (now − first) > `window_val`. A difference exactly equal to `window_val` requests no exit.
- R5: Every qualifying pause sets the last timestamp to `now`, including a pause that requests an exit.
- R6: Both differences are taken modulo 2^TS_W, so a burst continues correctly across a timestamp wraparound.
- R7: `exit_req` is high for exactly the one cycle after each triggering pause, and only then. `exit_reason` is 0 whenever `exit_req` is low. Reason codes: 0 none, 1 unconditional, 2 spin loop.
- R8: Reset clears both timestamps to zero and drives `exit_req` and `exit_reason` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ts | input | TS_W | Current free-running timestamp |
| pause_vld | input | 1 | Pause event strobe, one per cycle at most |
| cpl | input | PRIV_W | Current privilege level of the guest |
| uncond_en | input | 1 | Exit on every pause |
| loop_en | input | 1 | Enable spin-loop detection |
| gap_val | input | TS_W | Largest inter-pause distance that stays in one burst |
| window_val | input | TS_W | Largest burst length allowed without an exit |
| exit_req | output | 1 | One-cycle exit request |
| exit_reason | output | 2 | Exit cause: 0 none, 1 unconditional, 2 spin loop |

## Verification
The assertions check the following on every cycle: the unconditional exit and its reason, silence for pauses that do not qualify, frozen timestamps under an unconditional exit, the update of the last timestamp, the restart of the first timestamp, and the rule that no request appears without a trigger. The strict boundaries need the bench's scenarios, because only a chosen sequence of timestamps can show them. Those scenarios cover a gap difference exactly equal to the threshold, an exit exactly one tick past the window, a burst running across a wraparound, zeroed timestamps after reset, and pauses that must leave no trace in later decisions.

// File: rtl/spin_pause_pkg.sv
package spin_pause_pkg;
    typedef enum logic [1:0] {
        RSN_NONE   = 2'd0,
        RSN_UNCOND = 2'd1,
        RSN_SPIN   = 2'd2
    } exit_rsn_e;

    typedef enum logic {
        EXS_WATCH = 1'b0,
        EXS_RAISE = 1'b1
    } exit_state_e;
endpackage

// File: rtl/pause_qualify.sv
module pause_qualify #(
    parameter int PRIV_W = 2
) (
    input  logic              pause_vld,
    input  logic [PRIV_W-1:0] cpl,
    input  logic              uncond_en,
    input  logic              loop_en,
    output logic              hit_uncond,
    output logic              hit_loop
);
    localparam logic [PRIV_W-1:0] RING0 = '0;

    always_comb begin
        hit_uncond = pause_vld && uncond_en;
        hit_loop   = pause_vld && !uncond_en && loop_en && (cpl == RING0);
    end
endmodule

// File: rtl/pause_burst_eval.sv
module pause_burst_eval #(
    parameter int TS_W = 64
) (
    input  logic [TS_W-1:0] now_ts,
    input  logic [TS_W-1:0] first_ts,
    input  logic [TS_W-1:0] last_ts,
    input  logic [TS_W-1:0] gap_val,
    input  logic [TS_W-1:0] window_val,
    output logic            starts_burst,
    output logic            over_window
);
    logic [TS_W-1:0] since_last;
    logic [TS_W-1:0] since_first;

    always_comb begin
        // modular subtraction: wraparound of the timestamp is harmless
        since_last   = now_ts - last_ts;
        since_first  = now_ts - first_ts;
        starts_burst = since_last > gap_val;
        over_window  = !starts_burst && (since_first > window_val);
    end
endmodule

// File: rtl/pause_stamp_regs.sv
module pause_stamp_regs #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_loop,
    input  logic            starts_burst,
    input  logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] first_ts,
    output logic [TS_W-1:0] last_ts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_ts <= '0;
            last_ts  <= '0;
        end else if (hit_loop) begin
            last_ts <= now_ts;
            if (starts_burst) begin
                first_ts <= now_ts;
            end
        end
    end

    // R5: last timestamp follows every qualifying pause
    a_r5_last_updated: assert property (@(posedge clk) disable iff (!rst_n)
        hit_loop |=> last_ts == $past(now_ts));

    // R3: a new burst records its start time
    a_r3_burst_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_loop && starts_burst) |=> first_ts == $past(now_ts));

    // R2: without a qualifying pause the timestamps hold
    a_r2_stamps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_loop |=> ($stable(first_ts) && $stable(last_ts)));
endmodule

// File: rtl/pause_exit_fsm.sv
module pause_exit_fsm
    import spin_pause_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit_uncond,
    input  logic      hit_spin,
    output logic      exit_req,
    output exit_rsn_e exit_reason
);
    exit_state_e state_q, state_d;
    exit_rsn_e   rsn_q, rsn_d;

    always_comb begin
        state_d = state_q;
        rsn_d   = RSN_NONE;
        unique case (state_q)
            EXS_WATCH: begin
                if (hit_uncond || hit_spin) state_d = EXS_RAISE;
            end
            EXS_RAISE: begin
                if (!(hit_uncond || hit_spin)) state_d = EXS_WATCH;
            end
            default: state_d = EXS_WATCH;
        endcase
        if (hit_uncond)    rsn_d = RSN_UNCOND;
        else if (hit_spin) rsn_d = RSN_SPIN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXS_WATCH;
            rsn_q   <= RSN_NONE;
        end else begin
            state_q <= state_d;
            rsn_q   <= rsn_d;
        end
    end

    always_comb begin
        exit_req    = (state_q == EXS_RAISE);
        exit_reason = exit_req ? rsn_q : RSN_NONE;
    end

    // R1: unconditional control wins and is reported next cycle
    a_r1_uncond_exit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_uncond |=> (exit_req && exit_reason == RSN_UNCOND));

    // R4: spin detection reported next cycle with its own reason
    a_r4_spin_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_spin && !hit_uncond) |=> (exit_req && exit_reason == RSN_SPIN));

    // R7: no request without a trigger in the previous cycle
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_uncond || hit_spin) |=> !exit_req);
endmodule

// File: rtl/spin_pause_exit.sv
module spin_pause_exit
    import spin_pause_pkg::*;
#(
    parameter int TS_W   = 64,
    parameter int PRIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_ts,
    input  logic              pause_vld,
    input  logic [PRIV_W-1:0] cpl,
    input  logic              uncond_en,
    input  logic              loop_en,
    input  logic [TS_W-1:0]   gap_val,
    input  logic [TS_W-1:0]   window_val,
    output logic              exit_req,
    output logic [1:0]        exit_reason
);
    logic            hit_uncond, hit_loop;
    logic            starts_burst, over_window;
    logic [TS_W-1:0] first_ts, last_ts;
    exit_rsn_e       rsn;

    pause_qualify #(.PRIV_W(PRIV_W)) u_qual (
        .pause_vld (pause_vld),
        .cpl       (cpl),
        .uncond_en (uncond_en),
        .loop_en   (loop_en),
        .hit_uncond(hit_uncond),
        .hit_loop  (hit_loop)
    );

    pause_burst_eval #(.TS_W(TS_W)) u_eval (
        .now_ts      (now_ts),
        .first_ts    (first_ts),
        .last_ts     (last_ts),
        .gap_val     (gap_val),
        .window_val  (window_val),
        .starts_burst(starts_burst),
        .over_window (over_window)
    );

    pause_stamp_regs #(.TS_W(TS_W)) u_stamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_loop    (hit_loop),
        .starts_burst(starts_burst),
        .now_ts      (now_ts),
        .first_ts    (first_ts),
        .last_ts     (last_ts)
    );

    pause_exit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_uncond (hit_uncond),
        .hit_spin   (hit_loop && over_window),
        .exit_req   (exit_req),
        .exit_reason(rsn)
    );

    assign exit_reason = rsn;

    // R2: non-qualifying pauses with the unconditional control off stay silent
    a_r2_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_vld && !uncond_en && (!loop_en || cpl != '0)) |=> !exit_req);

    // R1: an unconditional exit leaves the burst timestamps alone
    a_r1_stamps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_vld && uncond_en) |=> ($stable(first_ts) && $stable(last_ts)));

    // R7: a request always carries a cause, idle carries none
    a_r7_reason_valid: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req == (exit_reason != 2'd0));
endmodule

// File: tb/tb_spin_pause_exit.sv
`timescale 1ns/100ps
module tb_spin_pause_exit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] now_ts = '0;
    logic        pause_vld = 1'b0;
    logic [1:0]  cpl = '0;
    logic        uncond_en = 1'b0;
    logic        loop_en = 1'b1;
    logic [63:0] gap_val = 64'd2000;
    logic [63:0] window_val = 64'd1000;
    logic        exit_req;
    logic [1:0]  exit_reason;

    int checks = 0;
    int failures = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic       cap = 1'b0;
    bit         done = 1'b0;

    spin_pause_exit dut (
        .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .pause_vld(pause_vld),
        .cpl(cpl), .uncond_en(uncond_en), .loop_en(loop_en),
        .gap_val(gap_val), .window_val(window_val),
        .exit_req(exit_req), .exit_reason(exit_reason)
    );

    always #2.5 clk = ~clk;

    task automatic ev(input logic [63:0] t, input logic [1:0] c, input logic u,
                      input logic l, input logic er, input logic [1:0] ec,
                      input string tag);
        @(posedge clk); #1;
        now_ts = t; cpl = c; uncond_en = u; loop_en = l; pause_vld = 1'b1;
        exp_q.push_back({er, ec});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            pause_vld = 1'b0;
        end
    endtask

    always @(posedge clk) cap <= pause_vld;

    // monitor: compares each produced result against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (cap) begin
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R7 result with empty scoreboard: got req=%0d rsn=%0d expected nothing",
                             exit_req, exit_reason);
                end else begin
                    logic [2:0] e;
                    string      tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if ({exit_req, exit_reason} !== e) begin
                        failures++;
                        $display("FAIL %s: got req=%0d rsn=%0d expected req=%0d rsn=%0d",
                                 tg, exit_req, exit_reason, e[2], e[1:0]);
                    end
                end
            end else if (exit_req !== 1'b0 || exit_reason !== 2'd0) begin
                failures++;
                $display("FAIL R7 idle cycle: got req=%0d rsn=%0d expected req=0 rsn=0",
                         exit_req, exit_reason);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] f;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (exit_req !== 1'b0 || exit_reason !== 2'd0) begin
            failures++;
            $display("FAIL R8 reset outputs: got req=%0d rsn=%0d expected 0 0", exit_req, exit_reason);
        end
        // R8: timestamps start at zero, so with a wide gap this pause is in a burst from 0
        ev(64'd1001, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, "R8 zero timestamps");
        idle(2);
        gap_val = 64'd100;
        // R3: new burst at 1500
        ev(64'd1500, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 new burst");
        for (int k = 1; k <= 10; k++)
            ev(64'd1500 + 64'(100 * k), 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R4 at or below window");
        ev(64'd2501, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, "R4 one tick past window");
        // R5: last moved to 2501, so 2601 is exactly the gap away and stays in the burst
        ev(64'd2601, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, "R5 last updated on exit");
        ev(64'd2702, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 gap plus one restarts");
        // R3: differences exactly equal to gap keep the burst opened at 2702
        for (int k = 1; k <= 10; k++)
            ev(64'd2702 + 64'(100 * k), 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R3 gap boundary keeps burst");
        ev(64'd3703, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, "R3 R4 exit after boundary run");
        idle(2);
        ev(64'd3800, 2'd3, 1'b0, 1'b1, 1'b0, 2'd0, "R2 nonzero privilege");
        // R2: 3800 left no trace, so 3850 is 147 after 3703 and restarts
        ev(64'd3850, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R2 ignored pause left no trace");
        ev(64'd9000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, "R2 detection disabled");
        idle(1);
        // R6: burst across wraparound
        f = 64'hFFFF_FFFF_FFFF_FFCE;
        ev(f, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R6 burst before wrap");
        for (int k = 1; k <= 10; k++)
            ev(f + 64'(100 * k), 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R6 wrapped within window");
        ev(f + 64'd1001, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, "R6 wrapped exit");
        // R1: priority over a pending spin exit
        ev(f + 64'd1002, 2'd0, 1'b1, 1'b1, 1'b1, 2'd1, "R1 unconditional priority");
        // R1: 1002 did not update last, so 1102 is 101 after 1001 and restarts
        ev(f + 64'd1102, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, "R1 timestamps untouched");
        ev(f + 64'd1200, 2'd2, 1'b1, 1'b0, 1'b1, 2'd1, "R1 unconditional at any privilege");
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R7 missing results: got %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule